// File: doc/BRIEF.md
# Functional-Unit Power-Gating Controller

This block decides, for each unit in a bank of arithmetic functional units (adders, multipliers), whether the unit's supply is switched on. A unit is switched off in one of two ways. Software can issue a sleep command that carries a unit mask. A unit can also be switched off by itself once it has gone without any operation for longer than a configurable idle limit. Switching off always passes through a pending stage. A sleep command that reaches a unit in a cycle where the unit is busy is held in that stage until the unit has a free cycle.

Once a unit is switched off, its supply is removed and its contents are lost. The unit is brought back by an explicit wake request or by an operation issued to it. Supply returns at once, but the unit's ready flag stays low for a fixed settle period. During that period a per-unit stall output tells the issue logic to hold operations for that unit. The stall is also raised in the same cycle that an operation is presented to a unit that is still off. The analog switches are not modelled here; the settle period stands in for them.

Top module: `fu_power_gate`

## Requirements
- R1: After reset every unit has `gate_en` and `ready` high and `stall` low.
- R2: A sleep command (`sleep_cmd` high, with bit i of `sleep_mask` selecting unit i) reaches an idle powered unit. The unit keeps `gate_en` and `ready` high in the next cycle, then drives both low in the cycle after that.
- R3: A unit whose mask bit is clear is unaffected by a sleep command.
- R4: A unit that sees no `active` strobe stays powered through its first IDLE_LIMIT+1 idle cycles after reset or after its last operation. After that it enters the pending stage and is switched off one idle cycle later.
- R5: An `active` strobe on a powered unit restarts its idle count from zero, so the automatic switch-off is delayed accordingly.
- R6: A `wake_req` to an off unit raises `gate_en` in the next cycle. `ready` then stays low and `stall` high for exactly SETTLE_CYCLES cycles, after which `ready` goes high and `stall` low.
- R7: An `active` strobe to an off unit raises that unit's `stall` in the same cycle and starts the same wake sequence as R6.
- R8: A sleep command that arrives while the unit is active is deferred. The unit stays powered and ready for as long as activity continues. It is switched off only after the first cycle without activity.
- R9: `ready` is never high while `gate_en` is low.
- R10: A `wake_req` to a unit in the pending stage cancels the switch-off, and the unit stays powered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| active | input | N_UNITS | Per-unit operation-issue strobe |
| sleep_cmd | input | 1 | Sleep command valid |
| sleep_mask | input | N_UNITS | Units targeted by the sleep command |
| wake_req | input | N_UNITS | Per-unit wake request |
| gate_en | output | N_UNITS | Supply switch enable per unit |
| ready | output | N_UNITS | Unit powered and settled |
| stall | output | N_UNITS | Hold issue to the unit |

## Verification
The assertions assume that `active`, `wake_req` and the sleep inputs are clean two-state values that change only away from the clock edge. They also assume the issue logic obeys `stall`, so no operation reaches a waking unit except as a strobe that the unit ignores. The stimulus drives every input one time unit after the rising edge and holds it for a full cycle. Each directed sequence starts from a fresh reset, so the idle counts of units that are not involved stay well below the limit.

// File: rtl/fu_power_gate.sv
module fu_power_gate #(
  parameter int N_UNITS       = 4,
  parameter int IDLE_LIMIT    = 100,
  parameter int SETTLE_CYCLES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_UNITS-1:0] active,
  input  logic               sleep_cmd,
  input  logic [N_UNITS-1:0] sleep_mask,
  input  logic [N_UNITS-1:0] wake_req,
  output logic [N_UNITS-1:0] gate_en,
  output logic [N_UNITS-1:0] ready,
  output logic [N_UNITS-1:0] stall
);

  localparam int CMAX = (IDLE_LIMIT > SETTLE_CYCLES) ? IDLE_LIMIT : SETTLE_CYCLES;
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] IDLE_TOP    = CW'(IDLE_LIMIT);
  localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CYCLES - 1);

  typedef enum logic [1:0] {S_ON, S_PEND, S_OFF, S_WAKE} pw_state_t;

  for (genvar g = 0; g < N_UNITS; g++) begin : g_unit
    pw_state_t     st;
    logic [CW-1:0] cnt;
    wire           hit = sleep_cmd & sleep_mask[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st  <= S_ON;
        cnt <= '0;
      end else begin
        case (st)
          S_ON: begin
            if (hit || (!active[g] && cnt == IDLE_TOP)) st <= S_PEND;
            if (active[g])            cnt <= '0;
            else if (cnt != IDLE_TOP) cnt <= cnt + 1'b1;
          end
          S_PEND: begin
            if (wake_req[g]) begin
              st  <= S_ON;
              cnt <= '0;
            end else if (!active[g]) begin
              st <= S_OFF;
            end
          end
          S_OFF: begin
            if (wake_req[g] || active[g]) begin
              st  <= S_WAKE;
              cnt <= '0;
            end
          end
          default: begin
            if (cnt == SETTLE_LAST) begin
              st  <= S_ON;
              cnt <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        endcase
      end
    end

    assign gate_en[g] = (st != S_OFF);
    assign ready[g]   = (st == S_ON) || (st == S_PEND);
    assign stall[g]   = (st == S_WAKE) || (st == S_OFF && active[g]);
  end

endmodule

// File: rtl/fu_power_gate_chk.sv
module fu_power_gate_chk #(
  parameter int N_UNITS       = 4,
  parameter int SETTLE_CYCLES = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_UNITS-1:0] active,
  input logic [N_UNITS-1:0] gate_en,
  input logic [N_UNITS-1:0] ready,
  input logic [N_UNITS-1:0] stall
);

  localparam int SW = $clog2(SETTLE_CYCLES + 2);

  for (genvar g = 0; g < N_UNITS; g++) begin : g_chk
    logic [SW-1:0] waited;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   waited <= '0;
      else if (gate_en[g] && !ready[g]) waited <= waited + 1'b1;
      else                          waited <= '0;
    end

    // R9
    ready_needs_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ready[g] |-> gate_en[g]);

    // R8
    off_after_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(gate_en[g]) |-> !$past(active[g]));

    // R7
    issue_wakes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!gate_en[g] && active[g]) |=> gate_en[g]);

    // R6
    power_up_unready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_en[g]) |-> (!ready[g] && stall[g]));

    // R6
    settle_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ready[g]) && waited != '0) |-> (waited == SW'(SETTLE_CYCLES)));
  end

endmodule

bind fu_power_gate fu_power_gate_chk #(
  .N_UNITS(N_UNITS),
  .SETTLE_CYCLES(SETTLE_CYCLES)
) i_chk (
  .clk(clk),
  .rst_n(rst_n),
  .active(active),
  .gate_en(gate_en),
  .ready(ready),
  .stall(stall)
);

// File: tb/test_fu_power_gate.sv
`timescale 1ns/1ps
module test_fu_power_gate;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] active = '0, sleep_mask = '0, wake_req = '0;
  logic         sleep_cmd = 1'b0;
  logic [N-1:0] gate_en, ready, stall;

  fu_power_gate #(.N_UNITS(N), .IDLE_LIMIT(100), .SETTLE_CYCLES(8)) i_fu_power_gate (
    .clk(clk), .rst_n(rst_n), .active(active), .sleep_cmd(sleep_cmd),
    .sleep_mask(sleep_mask), .wake_req(wake_req),
    .gate_en(gate_en), .ready(ready), .stall(stall));

  always #2.5 clk = ~clk;

  typedef struct {
    logic [N-1:0] g;
    logic [N-1:0] r;
    logic [N-1:0] s;
    string        tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails = 0;
  bit   done = 1'b0;

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (gate_en !== e.g || ready !== e.r || stall !== e.s) begin
        fails++;
        $display("FAIL %s: gate=%b ready=%b stall=%b expected gate=%b ready=%b stall=%b",
                 e.tag, gate_en, ready, stall, e.g, e.r, e.s);
      end
    end
  end

  task automatic cyc(input logic [N-1:0] a, input logic sc, input logic [N-1:0] sm,
                     input logic [N-1:0] wr, input logic [N-1:0] eg,
                     input logic [N-1:0] er, input logic [N-1:0] es, input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    active = a; sleep_cmd = sc; sleep_mask = sm; wake_req = wr;
    e.g = eg; e.r = er; e.s = es; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic do_reset();
    @(posedge clk);
    #1;
    rst_n = 1'b0; active = '0; sleep_cmd = 1'b0; sleep_mask = '0; wake_req = '0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R4 and R5: units 1..3 idle throughout, unit 0 active once in cycle 60
    for (int c = 1; c <= 165; c++) begin
      logic [N-1:0] on;
      on = '0;
      on[0] = (c < 163);
      for (int u = 1; u < N; u++) on[u] = (c < 102);
      cyc((c == 60) ? 4'b0001 : 4'b0000, 1'b0, '0, '0, on, on, 4'b0000,
          (c < 163) ? "R4 idle gating" : "R5 restarted idle count");
    end

    do_reset();
    cyc(4'b0000, 1'b0, 4'b0000, 4'b0000, 4'b1111, 4'b1111, 4'b0000, "R1 reset state");
    // R2 and R3: sleep units 2 and 3
    cyc(4'b0000, 1'b1, 4'b1100, 4'b0000, 4'b1111, 4'b1111, 4'b0000, "R2 command cycle");
    cyc(4'b0000, 1'b0, 4'b0000, 4'b0000, 4'b1111, 4'b1111, 4'b0000, "R2 pending");
    cyc(4'b0000, 1'b0, 4'b0000, 4'b0000, 4'b0011, 4'b0011, 4'b0000, "R3 masked units off");
    // R6: wake unit 2
    cyc(4'b0000, 1'b0, 4'b0000, 4'b0100, 4'b0011, 4'b0011, 4'b0000, "R6 wake issued");
    for (int k = 0; k < 8; k++)
      cyc(4'b0000, 1'b0, 4'b0000, 4'b0000, 4'b0111, 4'b0011, 4'b0100, "R6 settling");
    cyc(4'b0000, 1'b0, 4'b0000, 4'b0000, 4'b0111, 4'b0111, 4'b0000, "R6 settled");
    // R7: operation to off unit 3
    cyc(4'b1000, 1'b0, 4'b0000, 4'b0000, 4'b0111, 4'b0111, 4'b1000, "R7 same-cycle stall");
    for (int k = 0; k < 8; k++)
      cyc(4'b0000, 1'b0, 4'b0000, 4'b0000, 4'b1111, 4'b0111, 4'b1000, "R7 settling");
    cyc(4'b0000, 1'b0, 4'b0000, 4'b0000, 4'b1111, 4'b1111, 4'b0000, "R7 settled");
    // R8: sleep unit 0 while busy
    cyc(4'b0001, 1'b1, 4'b0001, 4'b0000, 4'b1111, 4'b1111, 4'b0000, "R8 command while busy");
    for (int k = 0; k < 3; k++)
      cyc(4'b0001, 1'b0, 4'b0000, 4'b0000, 4'b1111, 4'b1111, 4'b0000, "R8 deferred");
    cyc(4'b0000, 1'b0, 4'b0000, 4'b0000, 4'b1111, 4'b1111, 4'b0000, "R8 first quiet cycle");
    cyc(4'b0000, 1'b0, 4'b0000, 4'b0000, 4'b1110, 4'b1110, 4'b0000, "R8 off");
    // R10: cancel pending sleep of unit 1
    cyc(4'b0000, 1'b1, 4'b0010, 4'b0000, 4'b1110, 4'b1110, 4'b0000, "R10 command");
    cyc(4'b0000, 1'b0, 4'b0000, 4'b0010, 4'b1110, 4'b1110, 4'b0000, "R10 wake in pending");
    cyc(4'b0000, 1'b0, 4'b0000, 4'b0000, 4'b1110, 4'b1110, 4'b0000, "R10 cancelled");
    cyc(4'b0000, 1'b0, 4'b0000, 4'b0000, 4'b1110, 4'b1110, 4'b0000, "R10 stays on");

    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule